// File: doc/BRIEF.md
# Unsigned 32-by-16 Iterative Divider

This execution unit divides a 32-bit unsigned dividend by a 16-bit unsigned divisor. A single start strobe carries both operands in. After a fixed number of clock cycles the unit returns one packed 32-bit word. The upper half of that word holds the remainder and the lower half holds the quotient. The quotient is built one bit per cycle by restoring shift-and-subtract. The cycles before and after that loop are padded, so the latency does not depend on the operands.

The unit also returns condition flags. These are taken from the divisor, not from the result: a sign flag that copies the divisor's top bit, and a zero flag that is set when the divisor is zero. A five-bit update-enable vector pulses together with completion. It enables only the sign and zero flags and leaves the other three flags untouched.

An overflow output is raised when the upper half of the dividend is greater than or equal to the divisor, because the quotient would then not fit in 16 bits. The packed result has no defined meaning in that case, or when the divisor is zero. Even then, the unit completes on schedule and produces a repeatable value.

Top module: `udiv32x16`

## Requirements
- R1: When the divisor is nonzero and the dividend's upper 16 bits are below it, `result_o[15:0]` equals the integer quotient of dividend by divisor.
- R2: Under the same conditions, `result_o[31:16]` equals the remainder, which is always less than the divisor.
- R3: On completion, `flag_n_o` equals bit 15 of the divisor that was captured at start.
- R4: On completion, `flag_z_o` is 1 exactly when the captured divisor is zero.
- R5: `flag_upd_o` is 5'b01100 in the completion cycle and 5'b00000 in every other cycle. The bit positions are: H in bit 4, N in bit 3, Z in bit 2, V in bit 1 and C in bit 0.
- R6: If a start is sampled at clock edge k, then `done_o` is high for exactly one cycle, beginning at edge k+22. `busy_o` is high from edge k until that same edge.
- R7: On completion, `ovf_o` is 1 exactly when the dividend's upper 16 bits are greater than or equal to the divisor. This includes a zero divisor.
- R8: A start that arrives while `busy_o` is high is ignored. It changes neither the timing nor the result of the operation in progress.
- R9: `result_o`, `flag_n_o`, `flag_z_o` and `ovf_o` change only at a completion edge, and hold their values until the next one.
- R10: A zero divisor still completes in 22 cycles, with the zero flag set.
- R11: After reset, `busy_o` and `done_o` are low, and `result_o`, the flags, `ovf_o` and `flag_upd_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; accepted only while idle |
| dividend_i | input | 32 | Unsigned dividend, sampled with start |
| divisor_i | input | 16 | Unsigned divisor, sampled with start |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Remainder in bits 31:16, quotient in bits 15:0 |
| ovf_o | output | 1 | Quotient would not fit in 16 bits (or divisor is zero) |
| flag_n_o | output | 1 | Divisor sign-bit flag |
| flag_z_o | output | 1 | Divisor-is-zero flag |
| flag_upd_o | output | 5 | Per-flag update enables {H,N,Z,V,C} |

## Verification
A fault in the step counter shows at the ports at once: `done_o` arrives one or more cycles early or late, so the cycle-count check on the very first operation fails. A wrong restoring step corrupts a quotient bit or leaves the remainder at or above the divisor. Either error shows in the packed word at the first completion whose operands exercise that bit. Operand capture that is wrongly re-armed by a start during busy changes the result of the operation in progress. A flag register that follows the live divisor input instead of the captured one reports a mismatch on the next completion. A flag register that moves between completions fails the hold check within one cycle.

// File: rtl/udiv_pkg.sv
package udiv_pkg;
  localparam int unsigned FLG_C   = 0;
  localparam int unsigned FLG_V   = 1;
  localparam int unsigned FLG_Z   = 2;
  localparam int unsigned FLG_N   = 3;
  localparam int unsigned FLG_H   = 4;
  localparam int unsigned FLG_NUM = 5;

  localparam logic [FLG_NUM-1:0] FLG_WRITE_MASK =
    FLG_NUM'((1 << FLG_N) | (1 << FLG_Z));

  typedef struct packed {
    logic n;
    logic z;
    logic ovf;
  } udiv_flags_t;
endpackage

// File: rtl/udiv_ctrl.sv
module udiv_ctrl #(
  parameter int unsigned LATENCY    = 22,
  parameter int unsigned STEPS      = 16,
  parameter int unsigned STEP_FIRST = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic fin_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LATENCY);
  localparam logic [CNT_W-1:0] CNT_S0   = CNT_W'(STEP_FIRST);
  localparam logic [CNT_W-1:0] CNT_S1   = CNT_W'(STEP_FIRST + STEPS);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;

  assign load_o = start_i & ~busy_q;
  assign fin_o  = busy_q & (cnt_q == CNT_LAST);
  assign step_o = busy_q & (cnt_q >= CNT_S0) & (cnt_q < CNT_S1);
  assign busy_o = busy_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= fin_o;
      if (load_o) begin
        cnt_q  <= CNT_W'(1);
        busy_q <= 1'b1;
      end else if (fin_o) begin
        cnt_q  <= '0;
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q  <= cnt_q + CNT_W'(1);
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R6
  AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q); // R6
  AST_START_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !fin_o) |=> (busy_q && !done_q)); // R8
endmodule

// File: rtl/udiv_core.sv
module udiv_core #(
  parameter int unsigned DW = 32,
  parameter int unsigned VW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [VW-1:0] divisor_i,
  output logic [VW-1:0] quo_o,
  output logic [VW-1:0] rem_o
);
  logic [VW-1:0] rem_q, quo_q, dvs_q;
  logic [VW:0]   shifted, trial;
  logic          qbit;

  // partial remainder shifted left by one, next dividend bit pulled from quo_q
  assign shifted = {rem_q, quo_q[VW-1]};
  assign trial   = shifted - {1'b0, dvs_q};
  assign qbit    = ~trial[VW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load_i) begin
      rem_q <= dividend_i[DW-1:VW];
      quo_q <= dividend_i[VW-1:0];
      dvs_q <= divisor_i;
    end else if (step_i) begin
      rem_q <= qbit ? trial[VW-1:0] : shifted[VW-1:0];
      quo_q <= {quo_q[VW-2:0], qbit};
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && rem_q < dvs_q) |=> (rem_q < dvs_q)); // R2
endmodule

// File: rtl/udiv_flags.sv
module udiv_flags
  import udiv_pkg::*;
#(
  parameter int unsigned VW = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               fin_i,
  input  logic [VW-1:0]      dividend_hi_i,
  input  logic [VW-1:0]      divisor_i,
  output udiv_flags_t        flags_o,
  output logic [FLG_NUM-1:0] upd_o
);
  logic [VW-1:0]      dvs_q;
  logic               ovf_pend_q;
  udiv_flags_t        flags_q;
  logic [FLG_NUM-1:0] upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvs_q      <= '0;
      ovf_pend_q <= 1'b0;
      flags_q    <= '0;
      upd_q      <= '0;
    end else begin
      upd_q <= fin_i ? FLG_WRITE_MASK : '0;
      if (load_i) begin
        dvs_q      <= divisor_i;
        ovf_pend_q <= dividend_hi_i >= divisor_i;
      end
      if (fin_i) begin
        flags_q.n   <= dvs_q[VW-1];
        flags_q.z   <= dvs_q == '0;
        flags_q.ovf <= ovf_pend_q;
      end
    end
  end

  assign flags_o = flags_q;
  assign upd_o   = upd_q;

  AST_ZERO_IMPLIES_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_q.z |-> flags_q.ovf); // R7
endmodule

// File: rtl/udiv32x16.sv
module udiv32x16
  import udiv_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter int unsigned VW         = 16,
  parameter int unsigned LATENCY    = 22,
  parameter int unsigned STEP_FIRST = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [DW-1:0]      dividend_i,
  input  logic [VW-1:0]      divisor_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [DW-1:0]      result_o,
  output logic               ovf_o,
  output logic               flag_n_o,
  output logic               flag_z_o,
  output logic [FLG_NUM-1:0] flag_upd_o
);
  localparam int unsigned STEPS = VW;

  logic          load, step, fin;
  logic [VW-1:0] quo, rem;
  logic [DW-1:0] result_q;
  udiv_flags_t   flags;

  udiv_ctrl #(
    .LATENCY   (LATENCY),
    .STEPS     (STEPS),
    .STEP_FIRST(STEP_FIRST)
  ) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .fin_o  (fin),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  udiv_core #(
    .DW(DW),
    .VW(VW)
  ) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .step_i    (step),
    .dividend_i(dividend_i),
    .divisor_i (divisor_i),
    .quo_o     (quo),
    .rem_o     (rem)
  );

  udiv_flags #(
    .VW(VW)
  ) u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .fin_i        (fin),
    .dividend_hi_i(dividend_i[DW-1:VW]),
    .divisor_i    (divisor_i),
    .flags_o      (flags),
    .upd_o        (flag_upd_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) result_q <= '0;
    else if (fin) result_q <= {rem, quo};
  end

  assign result_o = result_q;
  assign ovf_o    = flags.ovf;
  assign flag_n_o = flags.n;
  assign flag_z_o = flags.z;

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> ($stable(result_o) && $stable(flags))); // R9
  AST_UPD_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flag_upd_o) == done_o); // R5
  AST_ZERO_NEEDS_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && flag_z_o |-> ovf_o); // R10
endmodule

// File: tb/udiv32x16_test.sv
module udiv32x16_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        busy, done, ovf, fn, fz;
  logic [31:0] result;
  logic [4:0]  upd;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  typedef struct {
    logic [31:0] a;
    logic [15:0] b;
    int          done_cyc;
  } item_t;
  item_t sb[$];

  logic [31:0] last_res;
  logic [2:0]  last_flg;
  bit          have_last = 0;

  udiv32x16 uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .dividend_i(dividend), .divisor_i(divisor),
    .busy_o(busy), .done_o(done), .result_o(result),
    .ovf_o(ovf), .flag_n_o(fn), .flag_z_o(fz), .flag_upd_o(upd)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      chk(upd == (done ? 5'b01100 : 5'b00000), "R5", 32'(upd),
          done ? 32'h0C : 32'h0);
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R6 unexpected done", 32'(cyc), 32'hFFFF_FFFF);
        end else begin
          item_t e;
          bit valid;
          bit e_ovf;
          e = sb.pop_front();
          e_ovf = e.a[31:16] >= e.b;
          valid = !e_ovf;
          chk(cyc == e.done_cyc, "R6 R8 R10 latency", 32'(cyc), 32'(e.done_cyc));
          chk(fn == e.b[15], "R3", 32'(fn), 32'(e.b[15]));
          chk(fz == (e.b == 16'h0), "R4", 32'(fz), 32'(e.b == 16'h0));
          chk(ovf == e_ovf, "R7", 32'(ovf), 32'(e_ovf));
          if (valid) begin
            chk(result[15:0] == 16'(e.a / 32'(e.b)), "R1", 32'(result[15:0]),
                32'(16'(e.a / 32'(e.b))));
            chk(result[31:16] == 16'(e.a % 32'(e.b)), "R2", 32'(result[31:16]),
                32'(16'(e.a % 32'(e.b))));
          end
        end
        last_res  = result;
        last_flg  = {fn, fz, ovf};
        have_last = 1;
      end else if (have_last) begin
        chk(result == last_res, "R9 result", result, last_res);
        chk({fn, fz, ovf} == last_flg, "R9 flags", 32'({fn, fz, ovf}), 32'(last_flg));
      end
    end
  end

  task automatic issue(input logic [31:0] a, input logic [15:0] b, input bit poke);
    item_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    dividend = a;
    divisor  = b;
    start    = 1'b1;
    e.a = a; e.b = b; e.done_cyc = cyc + 23;
    sb.push_back(e);
    @(negedge clk);
    start    = 1'b0;
    dividend = ~a;
    divisor  = ~b;
    chk(busy == 1'b1, "R6 busy", 32'(busy), 32'h1);
    if (poke) begin
      repeat (3) @(negedge clk);
      dividend = 32'h0000_0003;  // R8: ignored start with different operands
      divisor  = 16'h0001;
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R8 busy kept", 32'(busy), 32'h1);
    end
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !done, "R11 ctl", {30'h0, busy, done}, 32'h0);
    chk(result == 32'h0, "R11 result", result, 32'h0);
    chk({fn, fz, ovf, upd} == 8'h0, "R11 flags", 32'({fn, fz, ovf, upd}), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    issue(32'd100, 16'd7, 0);
    issue(32'h0000_FFFF, 16'h0001, 0);
    issue(32'h7FFF_FFFF, 16'h8000, 0);      // N set
    issue(32'h0000_0000, 16'h0005, 0);
    issue(32'h1234_5678, 16'h1235, 0);
    issue(32'h0004_FFFF, 16'h0005, 0);
    issue(32'h0005_0000, 16'h0005, 0);      // R7 boundary: equal
    issue(32'hFFFF_FFFF, 16'h1234, 0);      // R7 overflow
    issue(32'hDEAD_BEEF, 16'h0000, 0);      // R10 zero divisor
    issue(32'h0000_0000, 16'h0000, 0);      // R10
    issue(32'h00AB_CDEF, 16'hFFFF, 1);      // R8 poke
    issue(32'h0001_0000, 16'h0002, 1);      // R8 poke
    for (int i = 0; i < 40; i++) begin
      logic [15:0] b;
      logic [31:0] a;
      b = 16'($urandom());
      a = {16'($urandom()) % (b | 16'h1), 16'($urandom())};
      issue(a, b, i % 7 == 0);
    end
    for (int i = 0; i < 8; i++) issue($urandom(), 16'($urandom() & 32'h00FF), 0);

    while (sb.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule